// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous on-chip requester and an external fully static 64K x 32 asynchronous SRAM. A requester presents one access at a time as a request pulse with a write flag, a word address, write data and a four-bit lane mask. The controller then runs the memory's active-low strobes through a fixed sequence of phases. It returns read data together with a one-clock completion pulse.

The memory has no clock, so every timing limit becomes a whole number of system clocks. These limits are access time, write pulse width, data setup and output float time. Each phase length is a parameter, and one down-counter measures all of them. The defaults assume a 100 MHz clock and a 15 ns memory.

The shared data bus is split into an output word, an output-enable and an input word. The controller turns its driver on only in write phases, when the memory's output enable is held high. After every read it waits through a float phase before it will start another access.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until a request arrives, chip enable, write strobe, output enable and all four lane selects are high, the bus driver is off and the completion pulse is low.
- R2: A read request seen while idle makes chip enable and output enable go low for RD_CYC clocks, starting the clock after the request edge, with the write strobe high.
- R3: Read data is sampled from the bus at the end of the last access clock and appears on the read data output with the completion pulse. Lane i covers bits 8i+7 to 8i. A lane whose mask bit is 0 returns 8'h00.
- R4: A write request seen while idle produces three phases with chip enable low, each phase measured from the clock after the request edge. First, SETUP_CYC clocks with the write strobe high and the data driven. Next, WP_CYC clocks with the strobe low. Last, HOLD_CYC clocks with the strobe high and the data still driven.
- R5: The bus driver is on only in the three write phases. It is never on while output enable is low, or while the memory may still be driving the bus.
- R6: The read access is followed by FLOAT_CYC clocks with every strobe high and the driver off. No new request is accepted during these clocks.
- R7: A request is accepted only in an idle clock. A request held during a busy cycle has no effect on the pins and does not write the memory.
- R8: Address, lane selects and write data stay stable for as long as chip enable stays low.
- R9: Each accepted request produces exactly one completion pulse, one clock wide. For a read it comes on the first float clock. For a write it comes on the clock after the last hold clock, and a new request may be accepted in that same clock.
- R10: The write strobe is low only while chip enable is low, output enable is high and the bus driver is on.
- R11: Lane select i is low during a cycle exactly when mask bit i of the accepted request is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled while idle |
| req_we | input | 1 | 1 selects a write, 0 a read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Lane mask, bit i selects bits 8i+7:8i |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 32 | Read data, valid with done after a read |
| sram_addr | output | 16 | Memory address pins |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_bs_n | output | 4 | Memory lane selects, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| bus_dout | output | 32 | Data driven onto the shared bus |
| bus_oe | output | 1 | Bus driver enable |
| bus_din | input | 32 | Data seen on the shared bus |

## Verification
The hardest cases to reach are a write that starts right after a read, and a write that starts in the same clock that the previous write reports done. These are the two points where bus ownership or the strobes could overlap. The bench reaches them by holding a request high until the controller takes it, so each new access starts at the earliest clock the controller allows. Its memory model keeps driving the bus for one clock after output enable rises, so a missing float phase shows up as contention. The model also returns garbage until the access time has passed, so sampling too early returns the wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_FLOAT,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD
  } phase_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } strobe_t;

  localparam strobe_t STB_QUIET = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [LANES-1:0]   lane_en,
  input  logic [LANES*8-1:0] din,
  output logic [LANES*8-1:0] dout
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= 8'h00;
      end else if (capture) begin
        byte_q <= lane_en[i] ? din[8*i +: 8] : 8'h00;
      end
    end

    assign dout[8*i +: 8] = byte_q;
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int RD_CYC    = 2,
  parameter int FLOAT_CYC = 1,
  parameter int SETUP_CYC = 1,
  parameter int WP_CYC    = 1,
  parameter int HOLD_CYC  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                done,
  output logic [DATA_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]   sram_addr,
  output logic                sram_ce_n,
  output logic [DATA_W/8-1:0] sram_bs_n,
  output logic                sram_we_n,
  output logic                sram_oe_n,
  output logic [DATA_W-1:0]   bus_dout,
  output logic                bus_oe,
  input  logic [DATA_W-1:0]   bus_din
);

  localparam int LANES   = DATA_W / 8;
  localparam int MAX_A   = (RD_CYC > FLOAT_CYC) ? RD_CYC : FLOAT_CYC;
  localparam int MAX_B   = (SETUP_CYC > WP_CYC) ? SETUP_CYC : WP_CYC;
  localparam int MAX_C   = (MAX_B > HOLD_CYC) ? MAX_B : HOLD_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  phase_e             st_q, st_d;
  strobe_t            stb_q, stb_d;
  logic [LANES-1:0]   bs_n_q, bs_n_d;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [LANES-1:0]   be_q;
  logic [LANES-1:0]   be_src;
  logic               done_q, done_d;
  logic               accept;
  logic               capture;
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic               tmr_expired;

  assign accept = (st_q == ST_IDLE) && req;
  assign be_src = (st_q == ST_IDLE) ? req_be : be_q;

  // Phase sequencing
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    done_d   = 1'b0;
    capture  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          tmr_load = 1'b1;
          if (req_we) begin
            st_d    = ST_WR_SETUP;
            tmr_val = CNT_W'(SETUP_CYC - 1);
          end else begin
            st_d    = ST_RD_ACC;
            tmr_val = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_RD_ACC: begin
        if (tmr_expired) begin
          capture  = 1'b1;
          done_d   = 1'b1;
          st_d     = ST_RD_FLOAT;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(FLOAT_CYC - 1);
        end
      end
      ST_RD_FLOAT: begin
        if (tmr_expired) st_d = ST_IDLE;
      end
      ST_WR_SETUP: begin
        if (tmr_expired) begin
          st_d     = ST_WR_PULSE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WP_CYC - 1);
        end
      end
      ST_WR_PULSE: begin
        if (tmr_expired) begin
          st_d     = ST_WR_HOLD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HOLD_CYC - 1);
        end
      end
      ST_WR_HOLD: begin
        if (tmr_expired) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Strobe levels for the coming phase, registered so the pins never glitch
  always_comb begin
    unique case (st_d)
      ST_RD_ACC:               stb_d = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
      ST_WR_SETUP, ST_WR_HOLD: stb_d = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};
      ST_WR_PULSE:             stb_d = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
      default:                 stb_d = STB_QUIET;
    endcase
    bs_n_d = stb_d.ce_n ? '1 : ~be_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      stb_q  <= STB_QUIET;
      bs_n_q <= '1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      stb_q  <= stb_d;
      bs_n_q <= bs_n_d;
      done_q <= done_d;
    end
  end

  // Request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_lane_capture #(.LANES(LANES)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .lane_en (be_q),
    .din     (bus_din),
    .dout    (rd_data)
  );

  assign done      = done_q;
  assign sram_addr = addr_q;
  assign sram_ce_n = stb_q.ce_n;
  assign sram_we_n = stb_q.we_n;
  assign sram_oe_n = stb_q.oe_n;
  assign sram_bs_n = bs_n_q;
  assign bus_oe    = stb_q.drive;
  assign bus_dout  = wdata_q;

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                done,
  input logic [ADDR_W-1:0]   sram_addr,
  input logic                sram_ce_n,
  input logic [DATA_W/8-1:0] sram_bs_n,
  input logic                sram_we_n,
  input logic                sram_oe_n,
  input logic [DATA_W-1:0]   bus_dout,
  input logic                bus_oe
);

  a_r5_no_drive_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> sram_oe_n);

  a_r6_float_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |=> !bus_oe);

  a_r10_strobe_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && bus_oe && sram_oe_n));

  a_r2_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (sram_we_n && !sram_ce_n));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && !$past(sram_ce_n)) |-> ($stable(sram_addr) && $stable(sram_bs_n)));

  a_r8_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_dout));

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sram_cycle_ctrl_test.sv
module sram_cycle_ctrl_test;

  localparam int RD_CYC    = 2;
  localparam int FLOAT_CYC = 1;
  localparam int SETUP_CYC = 1;
  localparam int WP_CYC    = 1;
  localparam int HOLD_CYC  = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        done, sram_ce_n, sram_we_n, sram_oe_n, bus_oe;
  logic [31:0] rd_data, bus_dout;
  logic [31:0] bus_din;
  logic [15:0] sram_addr;
  logic [3:0]  sram_bs_n;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sram_cycle_ctrl #(
    .RD_CYC(RD_CYC), .FLOAT_CYC(FLOAT_CYC), .SETUP_CYC(SETUP_CYC),
    .WP_CYC(WP_CYC), .HOLD_CYC(HOLD_CYC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .done(done), .rd_data(rd_data),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_bs_n(sram_bs_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .bus_din(bus_din)
  );

  // Behavioural memory: drives after OE falls, keeps driving one clock after it rises,
  // and shows garbage until the access time has passed.
  logic [31:0] mem    [logic [15:0]];
  logic [31:0] shadow [logic [15:0]];
  logic        mem_drv;
  logic        mem_float_q = 1'b0;
  int          rd_age = 0;

  function automatic logic [31:0] mrd(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] srd(input logic [15:0] a);
    return shadow.exists(a) ? shadow[a] : 32'h0;
  endfunction

  assign mem_drv = !sram_ce_n && sram_we_n && !sram_oe_n;

  always @(posedge clk) begin
    logic [31:0] w;
    mem_float_q <= mem_drv;
    rd_age      <= mem_drv ? rd_age + 1 : 0;
    if (!sram_ce_n && !sram_we_n) begin
      w = mrd(sram_addr);
      for (int i = 0; i < 4; i++)
        if (!sram_bs_n[i]) w[8*i +: 8] = bus_dout[8*i +: 8];
      mem[sram_addr] = w;
    end
  end

  always @* begin
    logic [31:0] m;
    m = mrd(sram_addr);
    if (bus_oe) bus_din = bus_dout;
    else if (mem_drv) begin
      for (int i = 0; i < 4; i++)
        bus_din[8*i +: 8] = sram_bs_n[i] ? 8'hA5 :
                            (rd_age >= RD_CYC - 1) ? m[8*i +: 8] : 8'h5A;
    end else bus_din = 32'hCCCC_CCCC;
  end

  // Per-clock reference schedule
  typedef struct {
    logic        ce_n, we_n, oe_n, drv, done, idle, rchk;
    logic [3:0]  bs_n;
    logic [15:0] addr;
    logic [31:0] dat;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic last_acc;

  function automatic exp_t mk(logic ce, logic we, logic oe, logic drv, logic dn,
                              logic idl, logic rc, logic [3:0] bs, logic [15:0] a,
                              logic [31:0] d, string t);
    exp_t e;
    e.ce_n = ce; e.we_n = we; e.oe_n = oe; e.drv = drv; e.done = dn; e.idle = idl;
    e.rchk = rc; e.bs_n = bs; e.addr = a; e.dat = d; e.tag = t;
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic push_sched(input logic w, input logic [15:0] a, input logic [31:0] d,
                            input logic [3:0] b);
    logic [31:0] m;
    m = srd(a);
    if (w) begin
      for (int i = 0; i < 4; i++) if (b[i]) m[8*i +: 8] = d[8*i +: 8];
      shadow[a] = m;
      for (int i = 0; i < SETUP_CYC; i++) q.push_back(mk(0, 1, 1, 1, 0, 0, 0, ~b, a, d, "R4"));
      for (int i = 0; i < WP_CYC; i++)    q.push_back(mk(0, 0, 1, 1, 0, 0, 0, ~b, a, d, "R4"));
      for (int i = 0; i < HOLD_CYC; i++)  q.push_back(mk(0, 1, 1, 1, 0, 0, 0, ~b, a, d, "R4"));
      q.push_back(mk(1, 1, 1, 0, 1, 1, 0, 4'hF, a, d, "R9"));
    end else begin
      // R3: unselected lanes return zero
      for (int i = 0; i < 4; i++) if (!b[i]) m[8*i +: 8] = 8'h00;
      for (int i = 0; i < RD_CYC; i++) q.push_back(mk(0, 1, 0, 0, 0, 0, 0, ~b, a, '0, "R2"));
      q.push_back(mk(1, 1, 1, 0, 1, 0, 1, 4'hF, a, m, "R6"));
      for (int i = 1; i < FLOAT_CYC; i++) q.push_back(mk(1, 1, 1, 0, 0, 0, 0, 4'hF, a, '0, "R6"));
    end
  endtask

  task automatic compare(input exp_t e);
    chk({sram_ce_n, sram_we_n, sram_oe_n} == {e.ce_n, e.we_n, e.oe_n}, e.tag,
        {61'd0, sram_ce_n, sram_we_n, sram_oe_n}, {61'd0, e.ce_n, e.we_n, e.oe_n});
    chk(sram_bs_n == e.bs_n, "R11", {60'd0, sram_bs_n}, {60'd0, e.bs_n});
    chk(bus_oe == e.drv, "R5", {63'd0, bus_oe}, {63'd0, e.drv});
    chk(!(bus_oe && (mem_drv || mem_float_q)), "R5 contention", {63'd0, bus_oe}, 64'd0);
    chk(done == e.done, "R9", {63'd0, done}, {63'd0, e.done});
    if (!e.ce_n) chk(sram_addr == e.addr, "R8 addr", {48'd0, sram_addr}, {48'd0, e.addr});
    if (e.drv)   chk(bus_dout == e.dat, "R8 data", {32'd0, bus_dout}, {32'd0, e.dat});
    if (e.rchk)  chk(rd_data == e.dat, "R3", {32'd0, rd_data}, {32'd0, e.dat});
    if (!sram_we_n)
      chk(!sram_ce_n && bus_oe && sram_oe_n, "R10", {61'd0, sram_ce_n, bus_oe, sram_oe_n}, 64'd3);
  endtask

  task automatic cycle(input logic r, input logic w, input logic [15:0] a,
                       input logic [31:0] d, input logic [3:0] b);
    exp_t e;
    @(negedge clk);
    e = (q.size() != 0) ? q.pop_front()
                        : mk(1, 1, 1, 0, 0, 1, 0, 4'hF, '0, '0, rst_n ? "R7" : "R1");
    compare(e);
    req = r; req_we = w; req_addr = a; req_wdata = d; req_be = b;
    last_acc = rst_n && r && e.idle;
    if (last_acc) push_sched(w, a, d, b);
  endtask

  task automatic request(input logic w, input logic [15:0] a, input logic [31:0] d,
                         input logic [3:0] b);
    last_acc = 1'b0;
    while (!last_acc) cycle(1, w, a, d, b);
  endtask

  task automatic settle();
    while (q.size() != 0) cycle(0, 0, '0, '0, '0);
    cycle(0, 0, '0, '0, '0);
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] s;
    // R1: quiet pins during and after reset
    for (int i = 0; i < 4; i++) cycle(0, 0, '0, '0, '0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cycle(0, 0, '0, '0, '0);

    // R4 / R2 / R3: full-word write then read back
    request(1, 16'h0010, 32'h1122_3344, 4'hF); settle();
    request(0, 16'h0010, '0, 4'hF);            settle();
    // R11: partial write on lanes 0 and 2
    request(1, 16'h0010, 32'hAABB_CCDD, 4'b0101); settle();
    request(0, 16'h0010, '0, 4'hF);               settle();
    // R3: masked read returns zero in lanes 0 and 2
    request(0, 16'h0010, '0, 4'b1010);            settle();

    // R9: write accepted in the done clock of the previous write
    request(1, 16'h0020, 32'hDEAD_BEEF, 4'hF);
    request(1, 16'h0021, 32'h0BAD_F00D, 4'b0011);
    // R5 / R6: write issued at the first legal clock after a read
    request(0, 16'h0020, '0, 4'hF);
    request(1, 16'h0022, 32'h5555_AAAA, 4'hF);
    request(0, 16'h0021, '0, 4'hF);
    request(0, 16'h0022, '0, 4'hF);
    settle();

    // Top address, single upper lane, and an empty mask
    request(1, 16'hFFFF, 32'h7700_0000, 4'b1000); settle();
    request(1, 16'hFFFF, 32'h1111_1111, 4'b0000); settle();
    request(0, 16'hFFFF, '0, 4'hF);               settle();

    // R7: request held during a busy write is ignored
    request(1, 16'h0030, 32'hCAFE_0030, 4'hF);
    cycle(1, 1, 16'h0031, 32'hFFFF_FFFF, 4'hF);
    cycle(1, 1, 16'h0031, 32'hFFFF_FFFF, 4'hF);
    cycle(0, 0, '0, '0, '0);
    settle();
    request(0, 16'h0031, '0, 4'hF); settle();   // R7: still zero
    request(0, 16'h0030, '0, 4'hF); settle();

    // Mixed patterns
    s = 32'h1234_5678;
    for (int i = 0; i < 16; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      request(1, {8'h01, s[7:0]}, s, s[11:8]);
      request(0, {8'h01, s[7:0]}, '0, s[15:12] | 4'b0001);
    end
    settle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule